// File: doc/BRIEF.md
# Page Buffer Write Loader

This block holds a 128-byte scratch page buffer inside a flash controller, together with the command mode that fills it. While the controller is in array-read mode, every completed bus write is treated as a command byte. The three-write key sequence AAh, 55h, E0h switches it into buffer-load mode. From then on every bus write stores data into the buffer, at any offset and in any order, using either byte or 16-bit word addressing.

A gap timer watches the time from the end of one data write to the start of the next. When the gap reaches a limit derived from the clock frequency and a microsecond budget (30 µs by default), the block leaves load mode by itself and returns to array-read mode. The buffer keeps its contents. A separate read port returns any buffered word at any time.

The bus write strobe `bus_wr_n` is the combined active-low write enable and chip enable. It is sampled by `clk`. A falling edge is seen at the first clock edge where the strobe is low after being high. A rising edge is seen at the first clock edge where it is high after being low.

Top module: `pbl_page_loader`

## Requirements
- R1: After reset `load_mode` is 0 and every word read through `rd_word`/`rd_data` is 0000h.
- R2: Three completed writes whose `bus_din[7:0]` bytes are AAh, 55h and E0h, issued from array-read mode, set `load_mode` to 1 at the rising strobe edge of the third write.
- R3: A byte other than the expected one at any step of the key sequence returns the block to array-read mode. A full sequence must then start again with AAh.
- R4: Writes made outside load mode, including the key writes, leave the buffer contents unchanged.
- R5: In word mode (`word_mode`=1), `bus_addr[6:1]` selects the word, `bus_addr[0]` is ignored, and both bytes of that word take `bus_din[15:0]`.
- R6: In byte mode (`word_mode`=0), `bus_addr[0]`=0 writes the low byte and 1 writes the high byte of word `bus_addr[6:1]`. The byte comes from `bus_din[7:0]`, and the other byte of that word is unchanged.
- R7: The address is captured on the falling strobe edge. Data and `word_mode` are captured on the rising edge, so an address change while the strobe is low has no effect.
- R8: In load mode, a write whose falling edge comes fewer than LIMIT clock edges after the previous data write's rising edge is accepted, and `load_mode` stays 1. LIMIT = CLK_MHZ*TIMEOUT_US.
- R9: When the gap reaches LIMIT edges, `load_mode` drops to 0 at that edge. A falling edge seen on that exact edge is discarded, and the buffer contents are preserved.
- R10: The gap timer starts only at the first data write's rising edge. Any idle time between entering load mode and the first data write does not end the mode.
- R11: After a timeout the block again decodes writes as commands. A new key sequence re-enters load mode, and earlier buffer contents are still readable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr_n | input | 1 | Combined active-low write strobe |
| bus_addr | input | 7 | Byte address; bit 0 is the byte selector in byte mode |
| bus_din | input | 16 | Write data; command bytes use bits 7:0 |
| word_mode | input | 1 | 1 = 16-bit word addressing, 0 = byte addressing |
| rd_word | input | 6 | Word index for the read port |
| rd_data | output | 16 | Buffered word at `rd_word` (combinational) |
| load_mode | output | 1 | 1 while buffer-load mode is active |

## Verification
The hardest situation to reach is a falling strobe edge that lands on exactly the clock edge where the gap timer expires. The same run must also show that the neighbouring gap, one edge shorter, is still accepted. The write task used by the stimulus holds the strobe high for a stated number of clock edges. With that control, the bench places one write at a gap of LIMIT-1 edges and the following write at a gap of exactly LIMIT edges. It then checks through the read port that the second write left the buffer untouched.

// File: rtl/pbl_pkg.sv
package pbl_pkg;

  typedef enum logic [1:0] {
    ST_ARRAY = 2'd0,
    ST_KEY1  = 2'd1,
    ST_KEY2  = 2'd2,
    ST_LOAD  = 2'd3
  } pbl_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;
  localparam logic [7:0] KEY_PAGE   = 8'hE0;

  // gap budget in clock cycles
  function automatic int unsigned pbl_gap_cycles(input int unsigned mhz,
                                                 input int unsigned us);
    return mhz * us;
  endfunction

  // lane enables: bit0 = low byte, bit1 = high byte
  function automatic logic [1:0] pbl_lanes(input logic wmode, input logic sel_hi);
    if (wmode) return 2'b11;
    return sel_hi ? 2'b10 : 2'b01;
  endfunction

  // in byte mode the byte on the low data lines feeds either lane
  function automatic logic [15:0] pbl_align(input logic wmode, input logic [15:0] din);
    return wmode ? din : {din[7:0], din[7:0]};
  endfunction

  // key sequence decoding for one completed command write
  function automatic pbl_state_e pbl_key_step(input pbl_state_e st, input logic [7:0] b);
    case (st)
      ST_ARRAY: return (b == KEY_FIRST)  ? ST_KEY1 : ST_ARRAY;
      ST_KEY1:  return (b == KEY_SECOND) ? ST_KEY2 : ST_ARRAY;
      ST_KEY2:  return (b == KEY_PAGE)   ? ST_LOAD : ST_ARRAY;
      default:  return st;
    endcase
  endfunction

endpackage

// File: rtl/pbl_strobe_edges.sv
module pbl_strobe_edges (
  input  logic clk,
  input  logic rst_n,
  input  logic wr_n,
  output logic fall,
  output logic rise
);
  logic wr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_q <= 1'b1;
    else        wr_q <= wr_n;
  end

  assign fall = wr_q & ~wr_n;
  assign rise = ~wr_q & wr_n;

  AST_RISE_AFTER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !fall);  // R7
endmodule

// File: rtl/pbl_cmd_fsm.sv
module pbl_cmd_fsm
  import pbl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rise,
  input  logic [7:0] cmd_byte,
  input  logic       expire,
  output pbl_state_e state,
  output logic       load_mode
);
  pbl_state_e state_d;

  always_comb begin
    state_d = state;
    if (state == ST_LOAD) begin
      if (expire) state_d = ST_ARRAY;
    end else if (rise) begin
      state_d = pbl_key_step(state, cmd_byte);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_ARRAY;
    else        state <= state_d;
  end

  assign load_mode = (state == ST_LOAD);

  AST_TIMEOUT_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (load_mode && expire) |=> (state == ST_ARRAY));  // R9
  AST_KEY_ENTRY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_KEY2 && rise && cmd_byte == KEY_PAGE) |=> load_mode);  // R2
  AST_BAD_KEY: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_KEY1 && rise && cmd_byte != KEY_SECOND) |=> (state == ST_ARRAY));  // R3
endmodule

// File: rtl/pbl_gap_timer.sv
module pbl_gap_timer #(
  parameter int unsigned LIMIT = 7500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic arm,
  input  logic halt,
  output logic expire,
  output logic running
);
  localparam int unsigned CW = $clog2(LIMIT + 1);
  localparam logic [CW-1:0] LAST = CW'(LIMIT - 1);

  logic [CW-1:0] cnt;

  assign expire = running && (cnt == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (!active) begin
      running <= 1'b0;
      cnt     <= '0;
    end else if (arm) begin
      running <= 1'b1;
      cnt     <= '0;
    end else if (halt || expire) begin
      running <= 1'b0;
    end else if (running) begin
      cnt <= cnt + 1'b1;
    end
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> (cnt <= LAST));  // R8
  AST_EXPIRE_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !running);  // R9
  AST_ARM_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (arm && active) |=> (running && cnt == '0));  // R10
endmodule

// File: rtl/pbl_page_store.sv
module pbl_page_store #(
  parameter int unsigned WORDS = 64
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               we_lanes,
  input  logic [$clog2(WORDS)-1:0] widx,
  input  logic [15:0]              wdata,
  input  logic [$clog2(WORDS)-1:0] ridx,
  output logic [15:0]              rdata
);
  for (genvar g = 0; g < 2; g++) begin : g_lane
    logic [7:0] mem [WORDS];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        for (int i = 0; i < WORDS; i++) mem[i] <= 8'h00;
      end else if (we_lanes[g]) begin
        mem[widx] <= wdata[8*g +: 8];
      end
    end

    assign rdata[8*g +: 8] = mem[ridx];
  end
endmodule

// File: rtl/pbl_page_loader.sv
module pbl_page_loader
  import pbl_pkg::*;
#(
  parameter int unsigned CLK_MHZ    = 250,
  parameter int unsigned TIMEOUT_US = 30,
  parameter int unsigned PAGE_BYTES = 128
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_wr_n,
  input  logic [6:0]  bus_addr,
  input  logic [15:0] bus_din,
  input  logic        word_mode,
  input  logic [5:0]  rd_word,
  output logic [15:0] rd_data,
  output logic        load_mode
);
  localparam int unsigned WORDS  = PAGE_BYTES / 2;
  localparam int unsigned WIDX_W = $clog2(WORDS);
  localparam int unsigned LIMIT  = pbl_gap_cycles(CLK_MHZ, TIMEOUT_US);

  logic       fall, rise, expire, timer_run;
  logic       accept_fall, commit;
  logic       pend;
  logic [6:0] pend_addr;
  logic [1:0] we_lanes;
  pbl_state_e state;

  pbl_strobe_edges u_edges (
    .clk(clk), .rst_n(rst_n), .wr_n(bus_wr_n), .fall(fall), .rise(rise)
  );

  pbl_cmd_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .rise(rise), .cmd_byte(bus_din[7:0]),
    .expire(expire), .state(state), .load_mode(load_mode)
  );

  // a falling edge on the expiry edge is dropped
  assign accept_fall = fall && load_mode && !expire;
  assign commit      = rise && pend && load_mode;
  assign we_lanes    = commit ? pbl_lanes(word_mode, pend_addr[0]) : 2'b00;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      pend_addr <= '0;
    end else if (!load_mode) begin
      pend <= 1'b0;
    end else if (accept_fall) begin
      pend      <= 1'b1;
      pend_addr <= bus_addr;
    end else if (rise) begin
      pend <= 1'b0;
    end
  end

  pbl_gap_timer #(.LIMIT(LIMIT)) u_timer (
    .clk(clk), .rst_n(rst_n), .active(load_mode), .arm(commit),
    .halt(accept_fall), .expire(expire), .running(timer_run)
  );

  pbl_page_store #(.WORDS(WORDS)) u_store (
    .clk(clk), .rst_n(rst_n), .we_lanes(we_lanes),
    .widx(pend_addr[WIDX_W:1]), .wdata(pbl_align(word_mode, bus_din)),
    .ridx(rd_word[WIDX_W-1:0]), .rdata(rd_data)
  );

  AST_STORE_ONLY_LOADING: assert property (@(posedge clk) disable iff (!rst_n)
    (we_lanes != 2'b00) |-> (state == ST_LOAD));  // R4
  AST_EXPIRY_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && expire) |=> !pend);  // R9
  AST_FRESH_TIMER: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(load_mode) |-> !timer_run);  // R10
  AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !rise && load_mode) |=> $stable(pend_addr));  // R7
endmodule

// File: tb/pbl_page_loader_bench.sv
`timescale 1ns/1ps
module pbl_page_loader_bench;
  localparam int unsigned LIMIT = 250 * 30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr_n = 1'b1;
  logic [6:0]  bus_addr = '0;
  logic [15:0] bus_din = '0;
  logic        word_mode = 1'b1;
  logic [5:0]  rd_word = '0;
  logic [15:0] rd_data;
  logic        load_mode;

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] model [64];

  always #2 clk = ~clk;

  pbl_page_loader u_pbl_page_loader (
    .clk(clk), .rst_n(rst_n), .bus_wr_n(bus_wr_n), .bus_addr(bus_addr),
    .bus_din(bus_din), .word_mode(word_mode), .rd_word(rd_word),
    .rd_data(rd_data), .load_mode(load_mode)
  );

  // {word_mode, byte address, data}
  localparam logic [23:0] VEC [10] = '{
    {1'b1, 7'h3E, 16'hA55A}, {1'b0, 7'h00, 16'h0011},
    {1'b0, 7'h01, 16'h0022}, {1'b1, 7'h7F, 16'hBEEF},
    {1'b0, 7'h7E, 16'h00C3}, {1'b1, 7'h10, 16'h1234},
    {1'b0, 7'h11, 16'hFF99}, {1'b1, 7'h02, 16'hCAFE},
    {1'b0, 7'h3F, 16'h0077}, {1'b1, 7'h41, 16'h0F0F}
  };

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  task automatic check(input logic [15:0] act, input logic [15:0] exp, input string req);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic check_word(input int idx, input string req);
    rd_word = 6'(idx);
    #1;
    check(rd_data, model[idx], req);
  endtask

  // model of a buffer write, from the addressing rules
  task automatic model_put(input logic [6:0] a, input logic [15:0] d, input logic wm);
    if (wm) model[a[6:1]] = d;
    else if (a[0]) model[a[6:1]][15:8] = d[7:0];
    else model[a[6:1]][7:0] = d[7:0];
  endtask

  // strobe low for two edges, then high for 'hi' edges before returning
  task automatic wr(input logic [6:0] a, input logic [6:0] a_late,
                    input logic [15:0] d, input logic wm, input int hi);
    bus_addr = a; bus_din = d; word_mode = wm; bus_wr_n = 1'b0;
    @(negedge clk);
    bus_addr = a_late;
    @(negedge clk);
    bus_wr_n = 1'b1;
    repeat (hi) @(negedge clk);
  endtask

  task automatic enter_load();
    wr(7'h55, 7'h55, 16'h00AA, 1'b1, 2);
    wr(7'h2A, 7'h2A, 16'h0055, 1'b1, 2);
    wr(7'h55, 7'h55, 16'h00E0, 1'b1, 2);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog all actual=running expected=finished");
    summary();
  end

  initial begin
    for (int i = 0; i < 64; i++) model[i] = 16'h0000;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1: reset state
    check({15'd0, load_mode}, 16'd0, "R1 load_mode");
    for (int i = 0; i < 64; i++) check_word(i, "R1 reset word");

    // R3: broken key sequences
    wr(7'h0A, 7'h0A, 16'h00AA, 1'b1, 2);
    wr(7'h0A, 7'h0A, 16'h0012, 1'b1, 2);
    wr(7'h0A, 7'h0A, 16'h0055, 1'b1, 2);
    wr(7'h0A, 7'h0A, 16'h00E0, 1'b1, 2);
    check({15'd0, load_mode}, 16'd0, "R3 bad second key");
    wr(7'h0A, 7'h0A, 16'h00AA, 1'b1, 2);
    wr(7'h0A, 7'h0A, 16'h0055, 1'b1, 2);
    wr(7'h0A, 7'h0A, 16'h00AA, 1'b1, 2);
    wr(7'h0A, 7'h0A, 16'h00E0, 1'b1, 2);
    check({15'd0, load_mode}, 16'd0, "R3 bad third key");
    // R4: command writes did not touch word 5
    check_word(5, "R4 idle write ignored");

    // R2: entry
    enter_load();
    check({15'd0, load_mode}, 16'd1, "R2 entry");

    // R10: long wait before the first data write
    repeat (3 * LIMIT) @(negedge clk);
    check({15'd0, load_mode}, 16'd1, "R10 no timer before first write");

    // R5/R6: vector table
    for (int v = 0; v < 10; v++) begin
      wr(VEC[v][22:16], VEC[v][22:16], VEC[v][15:0], VEC[v][23], 3);
      model_put(VEC[v][22:16], VEC[v][15:0], VEC[v][23]);
      check_word(int'(VEC[v][22:17]), VEC[v][23] ? "R5 word write" : "R6 byte write");
    end
    for (int i = 0; i < 64; i++) check_word(i, "R5 R6 sweep");

    // R7: address changed while strobe low
    wr(7'h20, 7'h30, 16'h4321, 1'b1, 3);
    model_put(7'h20, 16'h4321, 1'b1);
    check_word(16, "R7 fall address used");
    check_word(24, "R7 late address unused");

    // R8: gap of LIMIT-1 accepted
    wr(7'h50, 7'h50, 16'h1111, 1'b1, LIMIT - 1);
    model_put(7'h50, 16'h1111, 1'b1);
    wr(7'h52, 7'h52, 16'h2222, 1'b1, LIMIT);
    model_put(7'h52, 16'h2222, 1'b1);
    check({15'd0, load_mode}, 16'd1, "R8 gap below limit");
    check_word(41, "R8 write stored");

    // R9: gap of exactly LIMIT ends the mode, write dropped
    wr(7'h54, 7'h54, 16'h3333, 1'b1, 2);
    check({15'd0, load_mode}, 16'd0, "R9 timeout exit");
    check_word(42, "R9 dropped write");
    check_word(31, "R9 contents kept");

    // R11: re-entry after timeout
    enter_load();
    check({15'd0, load_mode}, 16'd1, "R11 re-entry");
    wr(7'h05, 7'h05, 16'h00EE, 1'b0, 3);
    model_put(7'h05, 16'h00EE, 1'b0);
    check_word(2, "R11 byte write after re-entry");
    check_word(63, "R11 earlier contents");

    summary();
  end
endmodule